// File: doc/BRIEF.md
# Transfer Counter with Reload

This block holds the 16-bit byte count used by a storage-bus controller for DMA transfers. Software writes the count one byte at a time into pending registers; the count that is visible and in use is only replaced by the pending value when a command arrives with its DMA flag set. A transfer-information command turns that count into an effective transfer length: a zero count stands for 65536 bytes, and the result is clamped either by the magnitude of a signed pending-transfer size or, while a command is being captured, by a fixed 32-byte limit.

When a transfer-information command also carries the DMA flag, the effective length becomes the remaining-byte counter and the terminal-count flag drops. The memory-side engine reports consumed bytes. When the remaining count reaches zero, the terminal-count flag is set, the visible count reads zero and a one-clock done pulse is produced. This pulse serves as the interrupt request.

Top module: `tcnt_top`

## Requirements
- R1: After a synchronous reset, `cur_count`, `remain`, `eff_len`, `tc_flag`, `dma_mode` and `done` are all 0.
- R2: A write with `wr_addr` 0 stores `wr_data` as bits 7:0 of the pending count, and a write with `wr_addr` 1 stores it as bits 15:8. Either write clears `tc_flag` and leaves `cur_count` unchanged. Writes to any other address have no effect on the pending count.
- R3: A command whose bit 7 is 1 sets `dma_mode` and loads `cur_count` from the pending count on the next clock. A command whose bit 7 is 0 clears `dma_mode` and leaves `cur_count` unchanged.
- R4: A transfer-information command has bits 6:0 equal to 0x10. It uses the count as it stands after any reload by the same command, and a count of 0 is taken as 65536.
- R5: On a transfer-information command, `eff_len` becomes the smaller of that count and 32 when `capture` is 1. Otherwise it becomes the smaller of that count and the absolute value of the signed `pend_size`.
- R6: A transfer-information command with bit 7 set (0x90) loads `remain` with the effective length and clears `tc_flag`.
- R7: A consume strobe lowers `remain` by `consume_cnt` and saturates at 0. A consume in the same cycle as a load of `remain` is ignored.
- R8: When a consume brings a non-zero `remain` to 0, then on the next clock `tc_flag` is 1, `cur_count` is 0 unless a DMA command reloads it in that cycle, and `done` is 1.
- R9: `done` is high for exactly one clock, and it is never raised by a consume while `remain` is already 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 4 | Register offset of the write |
| wr_data | input | 8 | Write data |
| cmd_wr | input | 1 | Command write strobe |
| cmd_code | input | 8 | Command byte; bit 7 is the DMA flag |
| pend_size | input | 18 | Signed pending transfer size |
| capture | input | 1 | Command-capture mode flag |
| consume_vld | input | 1 | Consumed-bytes strobe |
| consume_cnt | input | 17 | Number of bytes consumed |
| cur_count | output | 16 | Visible current count |
| remain | output | 17 | Remaining DMA bytes |
| eff_len | output | 17 | Last effective transfer length |
| tc_flag | output | 1 | Terminal-count status |
| dma_mode | output | 1 | DMA mode of the last command |
| done | output | 1 | One-clock completion pulse |

## Verification
The assertions check the following on every clock:
- that a count write clears the terminal-count flag,
- that a DMA command reloads the visible count,
- that a start loads `remain` and clears the flag,
- that `remain` never rises without a load and drops by exactly the consumed amount,
- that `done` coincides with the flag and never lasts two clocks.

Only the bench scenarios can show that the clamp arithmetic is correct. This covers the 65536 substitution for a zero count, the capture limit of 32, and a negative pending size. The bench also shows that writes to other offsets leave the pending count alone, and that saturation and the collision between a start and a consume behave as required.

// File: rtl/tcnt_pkg.sv
package tcnt_pkg;
  localparam logic [6:0] OP_XFER_INFO = 7'h10;
  localparam int         DMA_BIT      = 7;
endpackage

// File: rtl/tcnt_shadow.sv
module tcnt_shadow #(
  parameter int CNT_W = 16,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [7:0]       wr_data,
  output logic [CNT_W-1:0] pend_cnt,
  output logic             cnt_wr
);
  localparam int NB = CNT_W / 8;
  logic [NB-1:0] hit;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign hit[i] = wr_en && (wr_addr == AW'(i));
    always_ff @(posedge clk) begin
      if (rst)         pend_cnt[i*8 +: 8] <= '0;
      else if (hit[i]) pend_cnt[i*8 +: 8] <= wr_data;
    end
  end

  assign cnt_wr = |hit;
endmodule

// File: rtl/tcnt_len.sv
module tcnt_len #(
  parameter int CNT_W   = 16,
  parameter int PEND_W  = 18,
  parameter int CAP_MAX = 32
) (
  input  logic                     capture,
  input  logic [CNT_W-1:0]         cnt_in,
  input  logic signed [PEND_W-1:0] pend_size,
  output logic [CNT_W:0]           eff
);
  localparam int LEN_W = CNT_W + 1;
  localparam int MW    = (LEN_W > PEND_W) ? LEN_W : PEND_W;

  logic [MW-1:0]     full_w, mag_w, lim_w, min_w;
  logic [PEND_W-1:0] mag;

  always_comb begin
    if (cnt_in == '0) full_w = MW'(1) << CNT_W;
    else              full_w = MW'(cnt_in);
    mag    = pend_size[PEND_W-1] ? PEND_W'(-pend_size) : PEND_W'(pend_size);
    mag_w  = MW'(mag);
    lim_w  = capture ? MW'(CAP_MAX) : mag_w;
    min_w  = (full_w < lim_w) ? full_w : lim_w;
    eff    = min_w[LEN_W-1:0];
  end
endmodule

// File: rtl/tcnt_remain.sv
module tcnt_remain #(
  parameter int LEN_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             dec_vld,
  input  logic [LEN_W-1:0] dec_amt,
  output logic [LEN_W-1:0] remain,
  output logic             fin_ev,
  output logic             done
);
  assign fin_ev = !load && dec_vld && (remain != '0) && (dec_amt >= remain);

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      done   <= 1'b0;
    end else begin
      done <= fin_ev;
      if (load)
        remain <= load_val;
      else if (dec_vld)
        remain <= (dec_amt >= remain) ? '0 : remain - dec_amt;
    end
  end

  // R7: without a load the count never rises
  a_r7_no_rise: assert property (@(posedge clk) disable iff (rst)
    !load |=> remain <= $past(remain));
  // R7: a partial consume drops the count by exactly the amount
  a_r7_exact_dec: assert property (@(posedge clk) disable iff (rst)
    (!load && dec_vld && dec_amt < remain) |=> remain == $past(remain) - $past(dec_amt));
  // R9: completion pulse lasts one clock
  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8: after completion nothing remains
  a_r8_done_empty: assert property (@(posedge clk) disable iff (rst)
    done |-> remain == '0);
endmodule

// File: rtl/tcnt_top.sv
module tcnt_top #(
  parameter int CNT_W   = 16,
  parameter int PEND_W  = 18,
  parameter int CAP_MAX = 32,
  parameter int AW      = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [7:0]               wr_data,
  input  logic                     cmd_wr,
  input  logic [7:0]               cmd_code,
  input  logic signed [PEND_W-1:0] pend_size,
  input  logic                     capture,
  input  logic                     consume_vld,
  input  logic [CNT_W:0]           consume_cnt,
  output logic [CNT_W-1:0]         cur_count,
  output logic [CNT_W:0]           remain,
  output logic [CNT_W:0]           eff_len,
  output logic                     tc_flag,
  output logic                     dma_mode,
  output logic                     done
);
  import tcnt_pkg::*;
  localparam int LEN_W = CNT_W + 1;

  logic [CNT_W-1:0] pend_cnt, cnt_src;
  logic             cnt_wr, is_dma, is_ti, start, fin_ev;
  logic [LEN_W-1:0] eff;

  tcnt_shadow #(.CNT_W(CNT_W), .AW(AW)) u_shadow (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pend_cnt(pend_cnt), .cnt_wr(cnt_wr)
  );

  assign is_dma  = cmd_wr && cmd_code[DMA_BIT];
  assign is_ti   = cmd_wr && (cmd_code[6:0] == OP_XFER_INFO);
  assign start   = is_ti && cmd_code[DMA_BIT];
  assign cnt_src = is_dma ? pend_cnt : cur_count;

  tcnt_len #(.CNT_W(CNT_W), .PEND_W(PEND_W), .CAP_MAX(CAP_MAX)) u_len (
    .capture(capture), .cnt_in(cnt_src), .pend_size(pend_size), .eff(eff)
  );

  tcnt_remain #(.LEN_W(LEN_W)) u_remain (
    .clk(clk), .rst(rst), .load(start), .load_val(eff),
    .dec_vld(consume_vld), .dec_amt(consume_cnt),
    .remain(remain), .fin_ev(fin_ev), .done(done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_count <= '0;
      tc_flag   <= 1'b0;
      dma_mode  <= 1'b0;
      eff_len   <= '0;
    end else begin
      if (is_dma)      cur_count <= pend_cnt;
      else if (fin_ev) cur_count <= '0;

      if (start)       tc_flag <= 1'b0;
      else if (fin_ev) tc_flag <= 1'b1;
      else if (cnt_wr) tc_flag <= 1'b0;

      if (cmd_wr) dma_mode <= cmd_code[DMA_BIT];
      if (is_ti)  eff_len  <= eff;
    end
  end

  // R2: a count write without completion leaves the flag low
  a_r2_wr_clears_tc: assert property (@(posedge clk) disable iff (rst)
    (cnt_wr && !fin_ev) |=> !tc_flag);
  // R3: DMA command reloads the visible count
  a_r3_reload: assert property (@(posedge clk) disable iff (rst)
    is_dma |=> (cur_count == $past(pend_cnt)) && dma_mode);
  // R6: start loads remaining count and clears the flag
  a_r6_start: assert property (@(posedge clk) disable iff (rst)
    start |=> (remain == $past(eff)) && !tc_flag);
  // R8: completion pulse coincides with terminal count
  a_r8_done_tc: assert property (@(posedge clk) disable iff (rst)
    done |-> tc_flag);
endmodule

// File: tb/sim_tcnt_top.sv
module sim_tcnt_top;
  logic               clk = 0;
  logic               rst;
  logic               wr_en;
  logic [3:0]         wr_addr;
  logic [7:0]         wr_data;
  logic               cmd_wr;
  logic [7:0]         cmd_code;
  logic signed [17:0] pend_size;
  logic               capture;
  logic               consume_vld;
  logic [16:0]        consume_cnt;
  logic [15:0]        cur_count;
  logic [16:0]        remain, eff_len;
  logic               tc_flag, dma_mode, done;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  tcnt_top u0 (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; cmd_wr = 0; consume_vld = 0;
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); idle();
  endtask

  task automatic cmd(input logic [7:0] c);
    @(negedge clk); cmd_wr = 1; cmd_code = c;
    @(negedge clk); idle();
  endtask

  task automatic eat(input logic [16:0] n);
    @(negedge clk); consume_vld = 1; consume_cnt = n;
    @(negedge clk); idle();
  endtask

  task automatic t_reset();
    check("R1 cur_count", cur_count, 0);
    check("R1 remain", remain, 0);
    check("R1 eff_len", eff_len, 0);
    check("R1 tc_flag", tc_flag, 0);
    check("R1 dma_mode", dma_mode, 0);
    check("R1 done", done, 0);
  endtask

  task automatic t_host_write();
    wr_reg(4'd0, 8'h34);
    wr_reg(4'd1, 8'h12);
    wr_reg(4'd2, 8'hFF);
    check("R2 cur_count unchanged", cur_count, 0);
    cmd(8'h80);
    check("R2/R3 reload value", cur_count, 16'h1234);
    check("R3 dma set", dma_mode, 1);
    wr_reg(4'd0, 8'h00);
    cmd(8'h00);
    check("R3 dma cleared", dma_mode, 0);
    check("R3 cur kept", cur_count, 16'h1234);
    wr_reg(4'd0, 8'h34);
  endtask

  task automatic t_clamp();
    pend_size = 18'sd100; capture = 0;
    cmd(8'h10);
    check("R5 pend clamp", eff_len, 100);
    check("R5 non-dma no load", remain, 0);
    pend_size = -18'sd5000;
    cmd(8'h10);
    check("R5 negative pend", eff_len, 16'h1234);
    capture = 1;
    cmd(8'h10);
    check("R5 capture limit", eff_len, 32);
    capture = 0;
    wr_reg(4'd0, 8'd20); wr_reg(4'd1, 8'd0);
    cmd(8'h90);
    check("R4 reload before len", eff_len, 20);
    check("R6 remain loaded", remain, 20);
    check("R6 tc cleared", tc_flag, 0);
  endtask

  task automatic t_zero_count();
    wr_reg(4'd0, 8'd0); wr_reg(4'd1, 8'd0);
    pend_size = 18'sd70000;
    cmd(8'h90);
    check("R4 zero means 65536", eff_len, 17'h10000);
    check("R6 remain 65536", remain, 17'h10000);
    eat(17'd1000);
    check("R7 partial consume", remain, 64536);
    check("R9 no done on partial", done, 0);
  endtask

  task automatic t_complete();
    wr_reg(4'd0, 8'd10);
    pend_size = 18'sd50;
    cmd(8'h90);
    check("R6 remain 10", remain, 10);
    eat(17'd4);
    check("R7 remain 6", remain, 6);
    eat(17'd9);
    check("R7 saturate", remain, 0);
    check("R8 done", done, 1);
    check("R8 tc set", tc_flag, 1);
    check("R8 cur zero", cur_count, 0);
    @(negedge clk);
    check("R9 done one clock", done, 0);
    eat(17'd3);
    check("R9 no done when empty", done, 0);
    check("R9 remain stays 0", remain, 0);
    wr_reg(4'd1, 8'd0);
    check("R2 write clears tc", tc_flag, 0);
  endtask

  task automatic t_collision();
    wr_reg(4'd0, 8'd8);
    pend_size = 18'sd100;
    @(negedge clk);
    cmd_wr = 1; cmd_code = 8'h90; consume_vld = 1; consume_cnt = 17'd3;
    @(negedge clk); idle();
    check("R7 consume ignored on load", remain, 8);
    check("R9 no done on load", done, 0);
  endtask

  initial begin
    rst = 1; idle(); wr_addr = 0; wr_data = 0; cmd_code = 0;
    pend_size = 0; capture = 0; consume_cnt = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_host_write();
    t_clamp();
    t_zero_count();
    t_complete();
    t_collision();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule